// File: doc/BRIEF.md
# Adaptive Cluster Fold Network

This block connects four data banks to four compute clusters. When a workload offers less data parallelism than four lanes, it folds the four bank streams onto two clusters, one cluster, or none. The folded words are serialized onto the remaining clusters, one word per cycle. This avoids moving the data through memory to regroup it. The block also drives a power enable for each cluster, so that idle clusters can be voltage gated.

Software writes a two-bit fold mode at any time. The write is held as pending, and it is applied only at the next boundary of a fixed reconfiguration window (`WINDOW_CYCLES`, 1000 cycles by default). The cluster count can therefore change at most once per window. Every routed word is marked with a per-cluster valid strobe.

Top module: `clusterFoldNet`

## Requirements
- R1: While reset is held, every power enable and valid strobe is low, every cluster data word is zero, and the applied mode is all-off.
- R2: Mode code 0 enables power for clusters 0 to 3, code 1 for clusters 0 and 1, code 2 for cluster 0 only, and code 3 for none. These enables apply from one cycle after the mode is applied.
- R3: A mode write is applied only at a window boundary. Boundaries fall at the clock edges numbered WINDOW_CYCLES, 2*WINDOW_CYCLES and so on, counting the first edge after reset release as edge 1. A write registered on the boundary edge itself waits for the following boundary. Until a pending mode is applied, the power enables and valid strobes do not change.
- R4: When several writes occur within one window, the last one is applied.
- R5: In mode 0, cluster c receives bank c every cycle, one cycle after the bank word is presented.
- R6: In mode 1, cluster 0 alternates bank 0 then bank 2, and cluster 1 alternates bank 1 then bank 3, one word per cycle.
- R7: In mode 2, cluster 0 receives banks 0, 1, 2 and 3 in that order, one per cycle, and then repeats.
- R8: In mode 3, no valid strobe is raised and all power enables stay low.
- R9: A cluster's power enable rises at least one cycle before its first valid word, and a valid strobe is never high while that cluster's power enable is low.
- R10: After each mode change the serialization restarts at bank 0. Clusters that are not active output zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Mode write strobe |
| modeWrData | input | 2 | Requested fold mode (0 full, 1 half, 2 quarter, 3 off) |
| bankData | input | 4*DATA_W | Bank words, bank b in bits [b*DATA_W +: DATA_W] |
| clusterData | output | 4*DATA_W | Routed words, cluster c in bits [c*DATA_W +: DATA_W] |
| clusterValid | output | 4 | Per-cluster routed-word strobe |
| clusterPowerEn | output | 4 | Per-cluster power enable |

## Verification
The bench places mode writes in the middle of a window and on the boundary edge itself. A design that applied the write immediately, or one edge early, would change the power enables before the expected edge number. Two writes in one window confirm that the newer mode wins over a stale one. Each switch is examined cycle by cycle: a design that raised a valid strobe together with its power enable, or dropped power while valid was still high, fails the overlap check. A design that did not restart the bank sequence, or swapped the half-mode bank pairing, delivers a wrong word in the first folded cycles.

// File: rtl/clusterFoldPkg.sv
package clusterFoldPkg;
  localparam int LANES = 4;
  localparam int SEL_W = $clog2(LANES);

  typedef enum logic [1:0] {
    MODE_FULL    = 2'd0,
    MODE_HALF    = 2'd1,
    MODE_QUARTER = 2'd2,
    MODE_OFF     = 2'd3
  } foldMode_e;

  typedef struct packed {
    foldMode_e         mode;
    logic [SEL_W-1:0]  phase;
  } foldCtrl_t;

  function automatic logic [LANES-1:0] laneMask(input foldMode_e m);
    case (m)
      MODE_FULL:    return 4'b1111;
      MODE_HALF:    return 4'b0011;
      MODE_QUARTER: return 4'b0001;
      default:      return 4'b0000;
    endcase
  endfunction

  function automatic logic [SEL_W-1:0] bankSelect(input foldMode_e m,
                                                  input logic [SEL_W-1:0] phase,
                                                  input logic [SEL_W-1:0] lane);
    case (m)
      MODE_HALF:    return {phase[0], lane[0]};
      MODE_QUARTER: return phase;
      default:      return lane;
    endcase
  endfunction
endpackage

// File: rtl/foldControl.sv
module foldControl
  import clusterFoldPkg::*;
#(
  parameter int WINDOW_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWrEn,
  input  logic [1:0]       modeWrData,
  output foldCtrl_t        ctrl,
  output logic [LANES-1:0] powerEn
);
  localparam int CNT_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] winCnt;
  logic             atBoundary;
  foldMode_e        pendingMode;
  foldMode_e        activeMode;
  foldMode_e        nextMode;
  logic [SEL_W-1:0] phase;

  assign atBoundary = (winCnt == LAST_CNT);
  assign nextMode   = atBoundary ? pendingMode : activeMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt      <= '0;
      pendingMode <= MODE_OFF;
      activeMode  <= MODE_OFF;
      phase       <= '0;
      powerEn     <= '0;
    end else begin
      winCnt <= atBoundary ? '0 : winCnt + 1'b1;
      if (modeWrEn) pendingMode <= foldMode_e'(modeWrData);
      activeMode <= nextMode;
      phase      <= (nextMode != activeMode) ? '0 : phase + 1'b1;
      // Union of old and new masks: new lanes power up early, old lanes drop late.
      powerEn    <= laneMask(nextMode) | laneMask(activeMode);
    end
  end

  assign ctrl.mode  = activeMode;
  assign ctrl.phase = phase;

  initial begin
    if (WINDOW_CYCLES < 2) $error("WINDOW_CYCLES must be at least 2");
  end

  // R3: window counter never leaves its range
  p_win_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= LAST_CNT);

  // R3: the applied mode changes only right after a boundary cycle
  p_mode_at_boundary_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeMode) |-> $past(atBoundary));

  // R8: applied off mode keeps every enable low after one settling cycle
  p_off_unpowered_r8: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode == MODE_OFF && $past(activeMode) == MODE_OFF) |-> powerEn == '0);
endmodule

// File: rtl/foldDatapath.sv
module foldDatapath
  import clusterFoldPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  foldCtrl_t               ctrl,
  input  logic [LANES-1:0]        powerEn,
  input  logic [LANES*DATA_W-1:0] bankData,
  output logic [LANES*DATA_W-1:0] clusterData,
  output logic [LANES-1:0]        clusterValid
);
  logic [LANES-1:0] activeMask;
  assign activeMask = laneMask(ctrl.mode);

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign sel = bankSelect(ctrl.mode, ctrl.phase, SEL_W'(lane));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        clusterData[lane*DATA_W +: DATA_W] <= '0;
        clusterValid[lane]                 <= 1'b0;
      end else begin
        clusterValid[lane]                 <= activeMask[lane];
        clusterData[lane*DATA_W +: DATA_W] <= activeMask[lane]
                                              ? bankData[int'(sel)*DATA_W +: DATA_W]
                                              : '0;
      end
    end

    // R9: power enable leads the first valid word by at least one cycle
    p_power_lead_r9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(clusterValid[lane]) |-> $past(powerEn[lane]));
  end

  // R9: no valid word on an unpowered cluster
  p_valid_needs_power_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clusterValid & ~powerEn) == '0);

  // R8: valid strobes only follow a mode other than off
  p_off_no_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clusterValid != '0) |-> $past(ctrl.mode) != MODE_OFF);

  // R7: quarter mode drives only cluster 0
  p_quarter_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clusterValid != '0 && $past(ctrl.mode) == MODE_QUARTER) |-> clusterValid == 4'b0001);
endmodule

// File: rtl/clusterFoldNet.sv
module clusterFoldNet
  import clusterFoldPkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int WINDOW_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeWrEn,
  input  logic [1:0]          modeWrData,
  input  logic [4*DATA_W-1:0] bankData,
  output logic [4*DATA_W-1:0] clusterData,
  output logic [3:0]          clusterValid,
  output logic [3:0]          clusterPowerEn
);
  foldCtrl_t ctrl;

  foldControl #(.WINDOW_CYCLES(WINDOW_CYCLES)) uControl (
    .clk       (clk),
    .rstN      (rstN),
    .modeWrEn  (modeWrEn),
    .modeWrData(modeWrData),
    .ctrl      (ctrl),
    .powerEn   (clusterPowerEn)
  );

  foldDatapath #(.DATA_W(DATA_W)) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .powerEn     (clusterPowerEn),
    .bankData    (bankData),
    .clusterData (clusterData),
    .clusterValid(clusterValid)
  );
endmodule

// File: tb/tb_clusterFoldNet.sv
module tb_clusterFoldNet;
  localparam int DW  = 16;
  localparam int WIN = 1000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeWrEn = 1'b0;
  logic [1:0]    modeWrData = 2'd0;
  logic [4*DW-1:0] bankData = '0;
  logic [4*DW-1:0] clusterData;
  logic [3:0]    clusterValid;
  logic [3:0]    clusterPowerEn;

  int total = 0;
  int passed = 0;
  int edgeCount = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) edgeCount <= 0;
    else       edgeCount <= edgeCount + 1;
  end

  clusterFoldNet #(.DATA_W(DW), .WINDOW_CYCLES(WIN)) dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .bankData(bankData), .clusterData(clusterData),
    .clusterValid(clusterValid), .clusterPowerEn(clusterPowerEn)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  function automatic logic [DW-1:0] word(input logic [4*DW-1:0] v, input int i);
    return v[i*DW +: DW];
  endfunction

  task automatic setBanks(input logic [DW-1:0] base);
    for (int b = 0; b < 4; b++) bankData[b*DW +: DW] = base + DW'(b);
  endtask

  task automatic writeMode(input logic [1:0] m);
    @(negedge clk);
    modeWrEn = 1'b1; modeWrData = m;
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  task automatic toBoundary();
    do @(negedge clk); while (edgeCount % WIN != 0);
  endtask

  // At the negedge just after a boundary edge; checks the hand-over cycles.
  task automatic expectSwitch(input string req, input logic [3:0] oldMask,
                              input logic [3:0] newMask);
    chk("R9", {req, " overlap power"}, 64'(clusterPowerEn), 64'(oldMask | newMask));
    chk("R3", {req, " valid unchanged at boundary"}, 64'(clusterValid), 64'(oldMask));
    @(negedge clk);
    chk("R2", {req, " power mask"}, 64'(clusterPowerEn), 64'(newMask));
    chk(req, "valid mask", 64'(clusterValid), 64'(newMask));
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1", "power in reset", 64'(clusterPowerEn), 64'h0);
    chk("R1", "valid in reset", 64'(clusterValid), 64'h0);
    chk("R1", "data in reset", 64'(clusterData), 64'h0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "off after release", 64'({clusterPowerEn, clusterValid}), 64'h0);
  endtask

  task automatic testBoundaryEdgeWrite();
    // Write registered on the boundary edge must wait one more window.
    while (edgeCount % WIN != WIN - 1) @(negedge clk);
    modeWrEn = 1'b1; modeWrData = 2'd0;
    @(negedge clk);
    modeWrEn = 1'b0;
    chk("R3", "boundary edge count", 64'(edgeCount), 64'(WIN));
    @(negedge clk);
    chk("R3", "write on boundary edge waits", 64'(clusterPowerEn), 64'h0);
    toBoundary();
    chk("R3", "next boundary edge count", 64'(edgeCount), 64'(2 * WIN));
    expectSwitch("R9", 4'b0000, 4'b1111);
  endtask

  task automatic testFull();
    setBanks(16'h1100);
    @(negedge clk);
    for (int c = 0; c < 4; c++)
      chk("R5", $sformatf("full lane %0d", c), 64'(word(clusterData, c)), 64'(16'h1100 + c));
    setBanks(16'h2200);
    @(negedge clk);
    for (int c = 0; c < 4; c++)
      chk("R5", $sformatf("full lane %0d new", c), 64'(word(clusterData, c)), 64'(16'h2200 + c));
  endtask

  task automatic testHalf();
    setBanks(16'h3300);
    writeMode(2'd1);
    repeat (10) @(negedge clk);
    chk("R3", "half pending", 64'(clusterPowerEn), 64'hF);
    toBoundary();
    expectSwitch("R6", 4'b1111, 4'b0011);
    for (int k = 0; k < 4; k++) begin
      chk("R6", $sformatf("half c0 step %0d", k), 64'(word(clusterData, 0)),
          64'(16'h3300 + ((k % 2) ? 2 : 0)));
      chk("R6", $sformatf("half c1 step %0d", k), 64'(word(clusterData, 1)),
          64'(16'h3300 + ((k % 2) ? 3 : 1)));
      chk("R10", $sformatf("half idle zero %0d", k), 64'(clusterData[4*DW-1:2*DW]), 64'h0);
      @(negedge clk);
    end
  endtask

  task automatic testQuarterLastWins();
    setBanks(16'h4400);
    writeMode(2'd3);
    repeat (300) @(negedge clk);
    writeMode(2'd2);
    chk("R3", "quarter pending", 64'(clusterPowerEn), 64'h3);
    toBoundary();
    expectSwitch("R4", 4'b0011, 4'b0001);
    for (int k = 0; k < 5; k++) begin
      chk(k == 0 ? "R10" : "R7", $sformatf("quarter step %0d", k),
          64'(word(clusterData, 0)), 64'(16'h4400 + (k % 4)));
      @(negedge clk);
    end
  endtask

  task automatic testOff();
    writeMode(2'd3);
    toBoundary();
    expectSwitch("R8", 4'b0001, 4'b0000);
    for (int k = 0; k < 20; k++) begin
      setBanks(DW'(16'h5500 + k * 4));
      @(negedge clk);
      if (k % 5 == 0)
        chk("R8", $sformatf("off quiet %0d", k), 64'({clusterPowerEn, clusterValid}), 64'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    setBanks(16'h0A00);
    testReset();
    testBoundaryEdgeWrite();
    testFull();
    testHalf();
    testQuarterLastWins();
    testOff();
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule